// File: doc/BRIEF.md
# Bridge PWM Output Steering

This block takes a single pulse-width waveform produced by a shared period/duty timebase and distributes it across four output pins, named A, B, C and D. A two-bit steering selection chooses one of four topologies: one modulated pin, a complementary half-bridge pair, or a full bridge driven in either direction. A four-bit mode word decides whether the block drives the pins at all. Its upper two bits must both be set for steering. Its lower two bits then give the active level of pin pair A/C and, separately, of pin pair B/D.

In half-bridge operation the two complementary outputs never overlap. Each turn-on waits a programmable number of clock cycles after the opposite output turns off. Steering, polarity and dead-band settings are captured into a shadow copy only on the cycle that marks the start of a PWM period. A configuration change therefore never cuts a pulse short. While the block is disabled, the shadow copy follows the inputs directly. Pins that a topology does not use have their drive-enable flags cleared, so they can be handed back to general-purpose I/O.

Top module: `pwm_steer`

## Requirements
- R1: After reset, every pin value and every drive-enable flag is 0.
- R2: Steering code 00 drives pin A with the PWM waveform. Only A's drive-enable is set. B, C and D are released.
- R3: Steering code 01 (forward bridge) drives D with the waveform and holds A active and B and C inactive. All four drive-enables are set.
- R4: Steering code 11 (reverse bridge) drives B with the waveform and holds C active and A and D inactive. All four drive-enables are set.
- R5: Steering code 10 (half bridge) drives A when the waveform is high and B when it is low. Only the drive-enables of A and B are set. C and D are released.
- R6: Mode bit 1 set makes pins A and C active-low. Mode bit 0 set makes pins B and D active-low. A clear bit means active-high. A released pin outputs its inactive level.
- R7: In half-bridge mode, A and B are never active together. After one of them turns off, the other turns on exactly N cycles later, where N is the dead-band count. With N = 0 the switch happens in the same cycle.
- R8: While the block is enabled, changes to mode, steering code and dead-band count take effect only through a cycle in which the period-start input is high. While the block is disabled, these changes are taken in every cycle.
- R9: While the block is disabled (one cycle after the enable input falls), all drive-enables are 0 and each pin shows its inactive level.
- R10: When the latched mode's upper two bits are not both 1, all pins output 0 and all drive-enables are 0.
- R11: A modulated pin reflects the PWM input sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Block enable |
| period_start_i | input | 1 | High for the first cycle of each PWM period |
| pwm_i | input | 1 | Raw PWM waveform from the timebase |
| mode_i | input | 4 | [3:2] = 11 selects steering; [1] A/C active-low; [0] B/D active-low |
| steer_cfg_i | input | 2 | 00 single, 01 forward bridge, 10 half bridge, 11 reverse bridge |
| dead_i | input | DB_W | Half-bridge dead band in clock cycles |
| pin_o | output | 4 | Pin values, bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = D |
| pin_oe_o | output | 4 | Drive-enable per pin, same bit order |

## Verification
The bench builds the block with DB_W = 4, so dead-band counts range from 0 to 15. Random settings therefore reach both the zero-gap switch and the largest count. Random periods are short, 8 to 31 cycles. As a result, dead bands often swallow whole short pulses, and a turn-on often still has to wait when the PWM input reverses mid-gap. Configuration inputs are scrambled in the middle of periods. This exercises the shadow capture against every combination of steering code, polarity and enable.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    localparam int unsigned NPIN = 4;

    typedef enum logic [1:0] {
        STEER_SINGLE = 2'b00,
        STEER_FWD    = 2'b01,
        STEER_HALF   = 2'b10,
        STEER_REV    = 2'b11
    } steer_cfg_e;

    typedef struct packed {
        logic       pwm_on;
        logic [1:0] pol;
        steer_cfg_e cfg;
    } steer_sh_s;

endpackage

// File: rtl/pwm_steer_shadow.sv
module pwm_steer_shadow
    import pwm_steer_pkg::*;
#(
    parameter int unsigned DB_W = 6
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            enable_i,
    input  logic            period_start_i,
    input  logic [3:0]      mode_i,
    input  logic [1:0]      steer_cfg_i,
    input  logic [DB_W-1:0] dead_i,
    output logic            en_o,
    output steer_sh_s       sh_o,
    output logic [DB_W-1:0] dead_o
);

    typedef struct packed {
        logic            en;
        steer_sh_s       sh;
        logic [DB_W-1:0] dead;
    } shadow_t;

    shadow_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.en = enable_i;
        if (!enable_i || period_start_i) begin
            s_d.sh.pwm_on = (mode_i[3:2] == 2'b11);
            s_d.sh.pol    = mode_i[1:0];
            s_d.sh.cfg    = steer_cfg_e'(steer_cfg_i);
            s_d.dead      = dead_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign en_o   = s_q.en;
    assign sh_o   = s_q.sh;
    assign dead_o = s_q.dead;

endmodule

// File: rtl/pwm_steer_deadband.sv
module pwm_steer_deadband #(
    parameter int unsigned DB_W = 6
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            hb_en_i,
    input  logic            target_i,
    input  logic [DB_W-1:0] dead_i,
    output logic            a_act_o,
    output logic            b_act_o
);

    localparam logic [DB_W-1:0] CNT_ONE = DB_W'(1);

    typedef struct packed {
        logic            a;
        logic            b;
        logic [DB_W-1:0] cnt;
    } db_t;

    db_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!hb_en_i) begin
            s_d = '0;
        end else if (s_q.a && !target_i) begin
            s_d.a = 1'b0;
            if (dead_i == '0) s_d.b = 1'b1;
            else              s_d.cnt = CNT_ONE;
        end else if (s_q.b && target_i) begin
            s_d.b = 1'b0;
            if (dead_i == '0) s_d.a = 1'b1;
            else              s_d.cnt = CNT_ONE;
        end else if (!s_q.a && !s_q.b) begin
            if (s_q.cnt >= dead_i) begin
                s_d.a = target_i;
                s_d.b = !target_i;
            end else begin
                s_d.cnt = s_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign a_act_o = s_q.a;
    assign b_act_o = s_q.b;

    // R7: the complementary pair never overlaps
    assert_no_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(s_q.a && s_q.b));

    // R7: a nonzero dead band forbids the opposite side turning on at once
    assert_gap_after_a_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(s_q.a) && $past(dead_i) != '0) |-> !s_q.b);

    assert_gap_after_b_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(s_q.b) && $past(dead_i) != '0) |-> !s_q.a);

endmodule

// File: rtl/pwm_steer_route.sv
module pwm_steer_route
    import pwm_steer_pkg::*;
(
    input  logic            en_i,
    input  steer_sh_s       sh_i,
    input  logic            mod_i,
    input  logic            a_act_i,
    input  logic            b_act_i,
    output logic [NPIN-1:0] pin_o,
    output logic [NPIN-1:0] oe_o
);

    logic [NPIN-1:0] act;
    logic [NPIN-1:0] used;

    // Active (polarity-free) level and usage for each pin; bit 0 = A .. bit 3 = D
    always_comb begin
        act  = '0;
        used = '0;
        unique case (sh_i.cfg)
            STEER_SINGLE: begin
                act  = {3'b000, mod_i};
                used = 4'b0001;
            end
            STEER_FWD: begin
                act  = {mod_i, 2'b00, 1'b1};
                used = 4'b1111;
            end
            STEER_HALF: begin
                act  = {2'b00, b_act_i, a_act_i};
                used = 4'b0011;
            end
            STEER_REV: begin
                act  = {1'b0, 1'b1, mod_i, 1'b0};
                used = 4'b1111;
            end
            default: begin
                act  = '0;
                used = '0;
            end
        endcase
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        localparam bit PAIR_AC = ((p % 2) == 0);
        logic low_lvl;
        logic drive;
        assign low_lvl  = PAIR_AC ? sh_i.pol[1] : sh_i.pol[0];
        assign drive    = en_i && sh_i.pwm_on && used[p];
        assign oe_o[p]  = drive;
        assign pin_o[p] = !sh_i.pwm_on ? 1'b0 :
                          drive        ? (act[p] ^ low_lvl) : low_lvl;
    end

endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
    import pwm_steer_pkg::*;
#(
    parameter int unsigned DB_W = 6
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            enable_i,
    input  logic            period_start_i,
    input  logic            pwm_i,
    input  logic [3:0]      mode_i,
    input  logic [1:0]      steer_cfg_i,
    input  logic [DB_W-1:0] dead_i,
    output logic [3:0]      pin_o,
    output logic [3:0]      pin_oe_o
);

    typedef struct packed {
        logic mod;
    } top_t;

    top_t            t_d, t_q;
    logic            en_q;
    steer_sh_s       sh_q;
    logic [DB_W-1:0] dead_q;
    logic            hb_en;
    logic            a_act, b_act;

    pwm_steer_shadow #(.DB_W(DB_W)) u_shadow (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .enable_i       (enable_i),
        .period_start_i (period_start_i),
        .mode_i         (mode_i),
        .steer_cfg_i    (steer_cfg_i),
        .dead_i         (dead_i),
        .en_o           (en_q),
        .sh_o           (sh_q),
        .dead_o         (dead_q)
    );

    always_comb begin
        t_d     = t_q;
        t_d.mod = pwm_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    assign hb_en = en_q && sh_q.pwm_on && (sh_q.cfg == STEER_HALF);

    pwm_steer_deadband #(.DB_W(DB_W)) u_deadband (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .hb_en_i  (hb_en),
        .target_i (pwm_i),
        .dead_i   (dead_q),
        .a_act_o  (a_act),
        .b_act_o  (b_act)
    );

    pwm_steer_route u_route (
        .en_i    (en_q),
        .sh_i    (sh_q),
        .mod_i   (t_q.mod),
        .a_act_i (a_act),
        .b_act_i (b_act),
        .pin_o   (pin_o),
        .oe_o    (pin_oe_o)
    );

    assert_off_no_drive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_q |-> (pin_oe_o == 4'b0000));

    assert_not_pwm_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sh_q.pwm_on |-> (pin_o == 4'b0000 && pin_oe_o == 4'b0000));

    assert_pins_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hb_en |-> !((pin_o[0] ^ sh_q.pol[1]) && (pin_o[1] ^ sh_q.pol[0])));

    assert_oe_held_mid_period_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !period_start_i && en_q) |=> $stable(pin_oe_o));

endmodule

// File: tb/pwm_steer_tb_top.sv
module pwm_steer_tb_top;

    localparam int unsigned DB_W = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            enable = 1'b0;
    logic            pstart = 1'b0;
    logic            pwm = 1'b0;
    logic [3:0]      mode = 4'b0000;
    logic [1:0]      cfg = 2'b00;
    logic [DB_W-1:0] dead = '0;
    logic [3:0]      pin_o;
    logic [3:0]      pin_oe_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model state
    bit       m_en = 0, m_pwm = 0, m_mod = 0, m_a = 0, m_b = 0;
    bit [1:0] m_pol = 0, m_cfg = 0;
    int       m_dead = 0, m_cnt = 0;

    always #5 clk = ~clk;

    pwm_steer #(.DB_W(DB_W)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .enable_i       (enable),
        .period_start_i (pstart),
        .pwm_i          (pwm),
        .mode_i         (mode),
        .steer_cfg_i    (cfg),
        .dead_i         (dead),
        .pin_o          (pin_o),
        .pin_oe_o       (pin_oe_o)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [7:0] expected();
        bit [3:0] a, u, p;
        bit [3:0] lo;
        lo = {m_pol[0], m_pol[1], m_pol[0], m_pol[1]};
        case (m_cfg)
            2'd0: begin a = {3'b0, m_mod};            u = 4'b0001; end
            2'd1: begin a = {m_mod, 1'b0, 1'b0, 1'b1}; u = 4'b1111; end
            2'd2: begin a = {2'b0, m_b, m_a};          u = 4'b0011; end
            default: begin a = {1'b0, 1'b1, m_mod, 1'b0}; u = 4'b1111; end
        endcase
        if (!m_pwm) return 8'h00;
        if (!m_en) return {lo, 4'b0000};
        for (int i = 0; i < 4; i++) p[i] = u[i] ? (a[i] ^ lo[i]) : lo[i];
        return {p, u};
    endfunction

    function automatic string tag_now();
        if (!m_en)  return "R9";
        if (!m_pwm) return "R10";
        case (m_cfg)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R5_R7";
            default: return "R4";
        endcase
    endfunction

    task automatic model_step();
        bit hb;
        hb = m_en && m_pwm && (m_cfg == 2'd2);
        if (!hb) begin
            m_a = 0; m_b = 0; m_cnt = 0;
        end else if (m_a && !pwm) begin
            m_a = 0;
            if (m_dead == 0) m_b = 1; else m_cnt = 1;
        end else if (m_b && pwm) begin
            m_b = 0;
            if (m_dead == 0) m_a = 1; else m_cnt = 1;
        end else if (!m_a && !m_b) begin
            if (m_cnt >= m_dead) begin m_a = pwm; m_b = !pwm; end
            else m_cnt++;
        end
        m_mod = pwm;
        if (!enable || pstart) begin
            m_pwm  = (mode[3:2] == 2'b11);
            m_pol  = mode[1:0];
            m_cfg  = cfg;
            m_dead = int'(dead);
        end
        m_en = enable;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag_now(), {pin_o, pin_oe_o}, expected());
    endtask

    task automatic load(bit [3:0] md, bit [1:0] c, int d);
        mode = md; cfg = c; dead = DB_W'(d); pstart = 1; enable = 1;
        tick();
        pstart = 0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int gap;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check("R1", {pin_o, pin_oe_o}, 8'h00);

        // R6 polarity sweep on forward bridge with the waveform high
        for (int pl = 0; pl < 4; pl++) begin
            pwm = 1;
            load({2'b11, 2'(pl)}, 2'b01, 0);
            tick();
            // active pattern D=1 C=0 B=0 A=1, flipped per pair
            check("R6", {4'b0, pin_o},
                  {4'b0, 1'b1 ^ pl[0], 1'b0 ^ pl[1], 1'b0 ^ pl[0], 1'b1 ^ pl[1]});
        end

        // R11 single mode follows input with one register
        load(4'b1100, 2'b00, 0);
        pwm = 0; tick();
        pwm = 1; tick();
        check("R11", {7'b0, pin_o[0]}, 8'h01);
        pwm = 0; tick();
        check("R11", {7'b0, pin_o[0]}, 8'h00);

        // R8 mid-period change ignored, then taken at period start
        cfg = 2'b01; mode = 4'b1111;
        tick(); tick();
        check("R8", {4'b0, pin_oe_o}, 8'h01);
        pstart = 1; tick(); pstart = 0;
        check("R8", {4'b0, pin_oe_o}, 8'h0F);

        // R7 dead band of 3 cycles measured at the pins
        pwm = 1;
        load(4'b1100, 2'b10, 3);
        repeat (8) tick();
        check("R7", {6'b0, pin_o[1:0]}, 8'h01);
        pwm = 0;
        gap = 0;
        tick();
        while (pin_o[1:0] == 2'b00 && gap < 20) begin gap++; tick(); end
        check("R7", 8'(gap), 8'd3);
        check("R7", {6'b0, pin_o[1:0]}, 8'h02);

        // R7 zero dead band switches in one cycle
        load(4'b1100, 2'b10, 0);
        pwm = 1; tick();
        check("R7", {6'b0, pin_o[1:0]}, 8'h01);

        // R10 non-steering mode
        load(4'b1000, 2'b01, 0);
        check("R10", {pin_o, pin_oe_o}, 8'h00);

        // R9 disable
        load(4'b1111, 2'b01, 0);
        enable = 0; tick();
        check("R9", {pin_o, pin_oe_o}, 8'hF0);

        // random periods
        for (int per = 0; per < 400; per++) begin
            int len, duty;
            len  = 8 + int'($urandom % 24);
            duty = int'($urandom % (len + 1));
            enable = ($urandom % 10) != 0;
            if (($urandom % 3) == 0) begin
                mode = (($urandom % 5) == 0) ? 4'($urandom) : {2'b11, 2'($urandom)};
                cfg  = 2'($urandom);
                dead = DB_W'($urandom);
            end
            for (int i = 0; i < len; i++) begin
                pstart = (i == 0);
                pwm    = (i < duty);
                if (i > 0 && ($urandom % 4) == 0) begin
                    mode = 4'($urandom);
                    cfg  = 2'($urandom);
                    dead = DB_W'($urandom);
                end
                tick();
            end
        end

        done = 1;
        summary();
        $finish;
    end

endmodule